// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Unit

This unit sits between a 32-bit integer datapath and a byte-addressable data memory. For every memory request it adds a signed 16-bit displacement to a base register value to form the effective address, steers store data onto the correct byte lanes with matching write enables, and pulls the addressed byte or the whole word back out of the returned memory word. A mode input chooses, per request, whether the lowest byte address of a word holds its least-significant byte (little-endian) or its most-significant byte (big-endian).

Word accesses must be four-byte aligned. A word request whose address has either of its two low bits set is blocked before it reaches memory, and the unit raises a fault pulse in its place. Reads from memory are combinational. The extracted load value is registered and appears one cycle after the request, together with a valid strobe.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base_addr` plus `disp` sign-extended to 32 bits, wrapping modulo 2^32. `mem_addr` carries that address with its two low bits forced to zero.
- R2: A word request whose effective address has nonzero bits 1:0 drives `mem_en` and `mem_we` low in the same cycle. In the next cycle it pulses `align_fault` and leaves `ld_valid` low, and memory is left unchanged.
- R3: An aligned word store drives `mem_we` = 4'b1111. In little-endian mode `mem_wdata` equals `wr_data`. In big-endian mode `mem_wdata` is `wr_data` with its bytes reversed.
- R4: A byte store asserts exactly one `mem_we` bit, the one whose index equals the effective address bits 1:0, and places `wr_data[7:0]` on all four lanes of `mem_wdata`.
- R5: A byte store leaves the other three bytes of the addressed word unchanged.
- R6: An aligned word load returns the memory word one cycle later with `ld_valid` high. In little-endian mode it is returned as read. In big-endian mode its bytes are reversed.
- R7: A byte load with `req_zext` = 0 returns, one cycle later, the byte at the effective address sign-extended from bit 7.
- R8: A byte load with `req_zext` = 1 returns that byte zero-extended, so bits 31:8 are zero.
- R9: Byte address offset k within a word travels on memory lane k, bits 8k+7:8k. A word written in little-endian mode has its least-significant byte at the lowest address. A word written in big-endian mode has its most-significant byte, register bits 31:24, at the lowest address.
- R10: While and right after `rst` is high, `ld_valid`, `align_fault` and `ld_data` are zero.
- R11: With `req_valid` low, `mem_en` and `mem_we` stay low, and no `ld_valid` or `align_fault` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_zext | input | 1 | Byte load zero-extends when 1 and sign-extends when 0 |
| big_endian | input | 1 | 1 = big-endian, 0 = little-endian ordering |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| wr_data | input | 32 | Store data from the register file |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 4 | Per-lane write enables, lane k = byte offset k |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Combinational read data, lane k = byte offset k |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |
| align_fault | output | 1 | Misaligned word request was blocked |

## Verification
The internal state is small: the pending-load strobe, the fault pulse and the result register. An error in any of them shows up one cycle after the request, as a missing, extra or wrong `ld_valid`, `align_fault` or `ld_data` that the scoreboard does not expect. An error in lane steering or endian selection shows up as wrong `mem_we` or `mem_wdata` in the request cycle itself. If such a fault corrupts memory without showing there, it is exposed by the next load of the touched word, which a byte model of memory kept in the bench predicts independently.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_BYTE = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;

  // sign-extend the displacement, then add with natural wrap
  assign disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o    = base_i + disp_sx;
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e                      size_i,
  input  logic                           big_i,
  input  logic [$clog2(DATA_W/8)-1:0]    off_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [DATA_W/8-1:0]            we_o,
  output logic [DATA_W-1:0]              data_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] repl;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign swapped[k*BYTE_W +: BYTE_W] = data_i[(LANES-1-k)*BYTE_W +: BYTE_W];
    assign repl[k*BYTE_W +: BYTE_W]    = data_i[BYTE_W-1:0];
    assign we_o[k] = (size_i == ACC_WORD) || (off_i == OFF_W'(k));
  end

  always_comb begin
    if (size_i == ACC_BYTE) data_o = repl;
    else if (big_i)         data_o = swapped;
    else                    data_o = data_i;
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  acc_size_e                      size_i,
  input  logic                           big_i,
  input  logic                           zext_i,
  input  logic [$clog2(DATA_W/8)-1:0]    off_i,
  input  logic [DATA_W-1:0]              rdata_i,
  output logic [DATA_W-1:0]              data_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned HI_W  = DATA_W - BYTE_W;

  logic [DATA_W-1:0] swapped;
  logic [BYTE_W-1:0] sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign swapped[k*BYTE_W +: BYTE_W] = rdata_i[(LANES-1-k)*BYTE_W +: BYTE_W];
  end

  // lane index equals byte offset within the word
  assign sel = rdata_i[off_i*BYTE_W +: BYTE_W];

  always_comb begin
    if (size_i == ACC_BYTE) begin
      if (zext_i) data_o = {{HI_W{1'b0}}, sel};
      else        data_o = {{HI_W{sel[BYTE_W-1]}}, sel};
    end else if (big_i) begin
      data_o = swapped;
    end else begin
      data_o = rdata_i;
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_store,
  input  logic                   req_byte,
  input  logic                   req_zext,
  input  logic                   big_endian,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic [DISP_W-1:0]      disp,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_en,
  output logic [DATA_W/8-1:0]    mem_we,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   ld_valid,
  output logic [DATA_W-1:0]      ld_data,
  output logic                   align_fault
);
  localparam int unsigned LANES = DATA_W / BYTE_W;
  localparam int unsigned OFF_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  acc_size_e         size;
  logic              misaligned;
  logic              ld_fire;
  logic [LANES-1:0]  steer_we;
  logic [DATA_W-1:0] aligned;

  lsu_ea_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ea (
    .base_i (base_addr),
    .disp_i (disp),
    .ea_o   (ea)
  );

  assign off        = ea[OFF_W-1:0];
  assign size       = req_byte ? ACC_BYTE : ACC_WORD;
  assign misaligned = (size == ACC_WORD) && (off != '0);

  lsu_store_steer #(.DATA_W(DATA_W)) u_st (
    .size_i (size),
    .big_i  (big_endian),
    .off_i  (off),
    .data_i (wr_data),
    .we_o   (steer_we),
    .data_o (mem_wdata)
  );

  lsu_load_align #(.DATA_W(DATA_W)) u_ld (
    .size_i  (size),
    .big_i   (big_endian),
    .zext_i  (req_zext),
    .off_i   (off),
    .rdata_i (mem_rdata),
    .data_o  (aligned)
  );

  assign mem_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_en   = req_valid && !misaligned;
  assign mem_we   = (mem_en && req_store) ? steer_we : '0;
  assign ld_fire  = mem_en && !req_store;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid    <= 1'b0;
      align_fault <= 1'b0;
      ld_data     <= '0;
    end else begin
      ld_valid    <= ld_fire;
      align_fault <= req_valid && misaligned;
      if (ld_fire) ld_data <= aligned;
    end
  end

  // misaligned word never reaches memory
  assert_misalign_block_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_byte && ea[OFF_W-1:0] != '0) |-> (!mem_en && mem_we == '0));

  assert_misalign_fault_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_byte && ea[OFF_W-1:0] != '0) |=> (align_fault && !ld_valid));

  assert_byte_we_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && req_byte) |-> ($countones(mem_we) == 1 && mem_we[ea[OFF_W-1:0]]));

  assert_load_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store && (req_byte || ea[OFF_W-1:0] == '0)) |=> ld_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!mem_en && mem_we == '0));

  assert_idle_no_result_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ld_valid && !align_fault));

  assert_zext_upper_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && $past(req_byte && req_zext)) |-> (ld_data[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/lsu_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_byte = 1'b0, req_zext = 1'b0;
  logic        big_endian = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
  logic        mem_en, ld_valid, align_fault;
  logic [3:0]  mem_we;

  always #4 clk = ~clk;

  lsu_lane_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_byte(req_byte), .req_zext(req_zext), .big_endian(big_endian),
    .base_addr(base_addr), .disp(disp), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .align_fault(align_fault)
  );

  // physical memory: lane k of a word = byte offset k
  logic [31:0] mem_words [64];
  logic [7:0]  ref_b [256];
  assign mem_rdata = mem_words[mem_addr[7:2]];
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (mem_we[k]) mem_words[mem_addr[7:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
  end

  int checks = 0;
  int fails  = 0;
  logic [32:0] exp_q [$];   // bit 32 = fault expected
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // driver: one request per cycle, predictions pushed into the scoreboard
  task automatic issue(input bit st, input bit by, input bit zx, input bit be,
                       input logic [31:0] base, input logic [15:0] dsp,
                       input logic [31:0] data, input string tag);
    logic [31:0] ea, exp_wd, exp_ld, wd_le;
    logic [3:0]  exp_we;
    bit          mis;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_byte = by; req_zext = zx;
    big_endian = be; base_addr = base; disp = dsp; wr_data = data;
    ea  = base + {{16{dsp[15]}}, dsp};
    mis = !by && (ea[1:0] != 2'b00);
    #1;
    chk(mem_addr == {ea[31:2], 2'b00}, {tag, " R1 addr"}, {1'b0, mem_addr}, {1'b0, ea[31:2], 2'b00});
    if (mis) begin
      chk(!mem_en && mem_we == 4'b0, {tag, " R2 blocked"}, {28'b0, mem_en, mem_we}, 33'd0);
      exp_q.push_back({1'b1, 32'b0}); tag_q.push_back({tag, " R2 fault"});
    end else if (st) begin
      if (by) begin
        exp_we = 4'b0001 << ea[1:0];
        exp_wd = {4{data[7:0]}};
        ref_b[ea[7:0]] = data[7:0];
      end else begin
        exp_we = 4'b1111;
        exp_wd = be ? bswap(data) : data;
        wd_le  = exp_wd;
        for (int k = 0; k < 4; k++) ref_b[ea[7:0] + 8'(k)] = wd_le[k*8 +: 8];
      end
      chk(mem_we == exp_we, {tag, by ? " R4 we" : " R3 we"}, {29'b0, mem_we}, {29'b0, exp_we});
      chk(mem_wdata == exp_wd, {tag, by ? " R4 wdata" : " R3 wdata"}, {1'b0, mem_wdata}, {1'b0, exp_wd});
    end else begin
      if (by) begin
        exp_ld = zx ? {24'b0, ref_b[ea[7:0]]} : {{24{ref_b[ea[7:0]][7]}}, ref_b[ea[7:0]]};
      end else begin
        exp_ld = {ref_b[ea[7:0]+8'd3], ref_b[ea[7:0]+8'd2], ref_b[ea[7:0]+8'd1], ref_b[ea[7:0]]};
        if (be) exp_ld = bswap(exp_ld);
      end
      exp_q.push_back({1'b0, exp_ld}); tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_byte = 1'b0;
    #1;
    chk(!mem_en && mem_we == 4'b0, {tag, " R11 idle"}, {28'b0, mem_en, mem_we}, 33'd0);
  endtask

  // monitor: compares results against the scoreboard
  always @(negedge clk) begin
    if (!rst && (ld_valid || align_fault)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected result", {align_fault, ld_data}, 33'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk({align_fault, ld_valid} == {e[32], !e[32]} && (e[32] || ld_data == e[31:0]),
            t, {align_fault, ld_data}, e);
      end
    end
  end

  bit timed_out = 1'b0;
  initial begin
    #(8 * 100000);
    timed_out = 1'b1;
  end

  initial begin
    for (int a = 0; a < 256; a++) ref_b[a] = 8'(a * 7 + 3);
    for (int w = 0; w < 64; w++)
      for (int k = 0; k < 4; k++) mem_words[w][k*8 +: 8] = 8'((4*w + k) * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ld_valid && !align_fault && ld_data == 32'b0, "R10 reset", {align_fault, ld_data}, 33'd0);
    rst = 1'b0;
    idle("t0");
    idle("t1");
    // R1: negative displacement and wrap past 2^32
    issue(0, 0, 0, 0, 32'h0000_0040, 16'hFFF0, 0, "R1 R6 neg disp load");
    issue(0, 0, 0, 0, 32'hFFFF_FFF0, 16'h0020, 0, "R1 R6 wrap load");
    // R3/R9 little-endian word store then byte loads
    issue(1, 0, 0, 0, 32'h20, 16'h0, 32'hA1B2_C3D4, "R3 R9 le store");
    issue(0, 1, 0, 0, 32'h20, 16'h0, 0, "R7 R9 le byte0");
    issue(0, 1, 0, 0, 32'h20, 16'h3, 0, "R7 R9 le byte3");
    issue(0, 1, 1, 0, 32'h20, 16'h0, 0, "R8 zext byte0");
    // big-endian
    issue(1, 0, 0, 1, 32'h24, 16'h0, 32'h1122_3344, "R3 R9 be store");
    issue(0, 1, 0, 1, 32'h24, 16'h0, 0, "R7 R9 be byte0");
    issue(0, 0, 0, 1, 32'h24, 16'h0, 0, "R6 be word");
    issue(0, 0, 0, 0, 32'h24, 16'h0, 0, "R6 R9 le view of be word");
    // byte stores, other bytes preserved
    issue(1, 1, 0, 0, 32'h28, 16'h2, 32'h0000_005F, "R4 byte store le");
    issue(1, 1, 0, 1, 32'h28, 16'h1, 32'hFFFF_FF80, "R4 byte store be");
    issue(0, 0, 0, 0, 32'h28, 16'h0, 0, "R5 word after byte stores");
    issue(0, 1, 0, 0, 32'h28, 16'h1, 0, "R7 negative byte");
    issue(0, 1, 1, 1, 32'h28, 16'h1, 0, "R8 zext negative byte");
    // misaligned words
    issue(0, 0, 0, 0, 32'h20, 16'h1, 0, "R2 mis load");
    issue(1, 0, 0, 1, 32'h20, 16'h2, 32'hDEAD_BEEF, "R2 mis store");
    issue(0, 0, 0, 0, 32'h20, 16'h0, 0, "R2 R5 mem unchanged");
    issue(0, 0, 0, 0, 32'h1C, 16'h7, 0, "R2 mis via disp");
    idle("t2");
    idle("t3");
    idle("t4");
    chk(exp_q.size() == 0, "R6 scoreboard drained", 33'(exp_q.size()), 33'd0);
    if (timed_out) chk(1'b0, "watchdog", 33'd1, 33'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge timed_out) begin
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule